// File: doc/BRIEF.md
# Integer narrowing shift-saturate unit

This unit narrows one integer element taken from an accumulator grid into a narrower output lane. The element is 16 or 32 bits wide and may be signed or unsigned. It goes through an arithmetic right shift of 0 to 31 places. The shift can round half up or truncate. The shifted value is then either clamped to the bounds of the output lane or cut to its low bits. The output lane is 8 or 16 bits wide. The clamp bounds are signed or unsigned, chosen apart from the signedness of the input.

The datapath itself is combinational. One register stage sits at the output and is qualified by a valid bit, so a result appears one clock after its input. Each accepted element carries its own control fields, so every element may use a different narrowing setting.

Top module: `nsu_top`

## Requirements
- R1: `out_valid_o` equals `in_valid_i` of the previous clock. An active-low asynchronous reset clears `out_valid_o` and `out_data_o` to zero.
- R2: `out_data_o` loads a new result only on a clock where `in_valid_i` is 1. Otherwise it holds its value, whatever the other inputs do.
- R3: With `in_wide_i`=1 the element is `in_data_i[31:0]`; with `in_wide_i`=0 it is `in_data_i[15:0]`, and bits 31:16 are ignored. The element is sign-extended when `in_signed_i`=1 and zero-extended otherwise.
- R4: The extended element is shifted right arithmetically by `shift_i` (0 to 31). A negative value fills with ones.
- R5: With `round_en_i`=1 and a nonzero shift, 2^(shift-1) is added before the shift. With a zero shift, or with `round_en_i`=0, nothing is added.
- R6: With `sat_en_i`=0 the result is the low w bits of the shifted value.
- R7: With `sat_en_i`=1, `in_signed_i`=1 and `out_signed_i`=1, the result is clamped to [-2^(w-1), 2^(w-1)-1].
- R8: With `sat_en_i`=1, `in_signed_i`=1 and `out_signed_i`=0, the result is clamped to [0, 2^w-1].
- R9: With `sat_en_i`=1 and `in_signed_i`=0, only the upper bound applies. It is 2^(w-1)-1 when `out_signed_i`=1 and 2^w-1 otherwise.
- R10: w is 16 when `out_w16_i`=1 and 8 when it is 0. An 8-bit result sits in `out_data_o[7:0]` with bits 15:8 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Element and controls are valid |
| in_data_i | input | 32 | Input element; only the low 16 bits are used for narrow input |
| in_wide_i | input | 1 | 1: 32-bit element, 0: 16-bit element |
| in_signed_i | input | 1 | Element is signed |
| out_signed_i | input | 1 | Saturation bounds are signed |
| sat_en_i | input | 1 | Saturate (1) or truncate (0) |
| round_en_i | input | 1 | Rounding shift (1) or truncating shift (0) |
| shift_i | input | 5 | Right shift amount |
| out_w16_i | input | 1 | Output lane width: 1 = 16 bits, 0 = 8 bits |
| out_valid_o | output | 1 | Result is valid |
| out_data_o | output | 16 | Narrowed result |

## Verification
The bench builds the unit with its default parameters: a 32-bit maximum input, a 16-bit maximum output and a 5-bit shift. With these values both input widths, both output widths and the full shift range of 0 to 31 can be reached. This includes a shift of 31 with rounding on a 32-bit unsigned element, where the rounding addend is 2^30 and the sum needs two guard bits above the input width. Directed cases hit each clamp bound exactly and one step past it. A seeded pseudo-random sweep covers the legal width pairs against a reference model.

// File: rtl/nsu_pkg.sv
package nsu_pkg;
  localparam int SH_W = 5;

  typedef struct packed {
    logic            in_wide;
    logic            in_signed;
    logic            out_signed;
    logic            sat_en;
    logic            round_en;
    logic            out_w16;
    logic [SH_W-1:0] shift;
  } nsu_ctrl_t;
endpackage

// File: rtl/nsu_extend.sv
module nsu_extend
  import nsu_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int EXT_W = IN_W + 2
) (
  input  logic [IN_W-1:0]         data_i,
  input  nsu_ctrl_t               ctrl_i,
  output logic signed [EXT_W-1:0] ext_o
);
  localparam int HALF_W = IN_W / 2;

  logic fill_wide, fill_half;

  always_comb begin
    fill_wide = ctrl_i.in_signed & data_i[IN_W-1];
    fill_half = ctrl_i.in_signed & data_i[HALF_W-1];
    if (ctrl_i.in_wide)
      ext_o = {{(EXT_W-IN_W){fill_wide}}, data_i};
    else
      ext_o = {{(EXT_W-HALF_W){fill_half}}, data_i[HALF_W-1:0]};
  end
endmodule

// File: rtl/nsu_shift.sv
module nsu_shift
  import nsu_pkg::*;
#(
  parameter int EXT_W = 34
) (
  input  logic signed [EXT_W-1:0] ext_i,
  input  nsu_ctrl_t               ctrl_i,
  output logic signed [EXT_W-1:0] shifted_o
);
  logic signed [EXT_W-1:0] rnd_add;
  logic signed [EXT_W-1:0] sum;

  always_comb begin
    rnd_add = '0;
    if (ctrl_i.round_en && (ctrl_i.shift != '0))
      rnd_add = EXT_W'(1) << (ctrl_i.shift - 1'b1);
    sum       = ext_i + rnd_add;
    shifted_o = sum >>> ctrl_i.shift;
  end

  always_comb begin
    if (ctrl_i.shift == '0 && !ctrl_i.round_en)
      AST_ZERO_SHIFT_IDENT: assert (shifted_o == ext_i); // R5
    if (!ctrl_i.in_signed)
      AST_UNS_NONNEG: assert (!shifted_o[EXT_W-1]); // R9
  end
endmodule

// File: rtl/nsu_clamp.sv
module nsu_clamp
  import nsu_pkg::*;
#(
  parameter int EXT_W = 34,
  parameter int OUT_W = 16
) (
  input  logic signed [EXT_W-1:0] val_i,
  input  nsu_ctrl_t               ctrl_i,
  output logic [OUT_W-1:0]        res_o
);
  localparam int NW = 2;  // lane width variants: OUT_W/2, OUT_W

  logic signed [EXT_W-1:0] hi_s [NW];
  logic signed [EXT_W-1:0] lo_s [NW];
  logic signed [EXT_W-1:0] hi_u [NW];

  for (genvar g = 0; g < NW; g++) begin : g_bounds
    localparam int W = OUT_W >> (NW - 1 - g);
    assign hi_s[g] = (EXT_W'(1) << (W - 1)) - EXT_W'(1);
    assign lo_s[g] = -(EXT_W'(1) << (W - 1));
    assign hi_u[g] = (EXT_W'(1) << W) - EXT_W'(1);
  end

  logic signed [EXT_W-1:0] hi, lo, v;
  logic                    sel;

  always_comb begin
    sel = ctrl_i.out_w16;
    hi  = ctrl_i.out_signed ? hi_s[sel] : hi_u[sel];
    lo  = ctrl_i.out_signed ? lo_s[sel] : '0;
    v   = val_i;
    if (ctrl_i.sat_en) begin
      if (v > hi) v = hi;
      else if (ctrl_i.in_signed && (v < lo)) v = lo;
    end
    if (ctrl_i.out_w16) res_o = v[OUT_W-1:0];
    else                res_o = {{(OUT_W/2){1'b0}}, v[OUT_W/2-1:0]};
  end

  always_comb begin
    if (ctrl_i.sat_en && ctrl_i.in_signed && val_i < lo)
      AST_CLAMP_LOW: assert (v == lo); // R7
  end
endmodule

// File: rtl/nsu_top.sv
module nsu_top
  import nsu_pkg::*;
#(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [IN_W-1:0]  in_data_i,
  input  logic             in_wide_i,
  input  logic             in_signed_i,
  input  logic             out_signed_i,
  input  logic             sat_en_i,
  input  logic             round_en_i,
  input  logic [SH_W-1:0]  shift_i,
  input  logic             out_w16_i,
  output logic             out_valid_o,
  output logic [OUT_W-1:0] out_data_o
);
  localparam int EXT_W = IN_W + 2;

  nsu_ctrl_t               ctrl;
  logic signed [EXT_W-1:0] ext, shifted;
  logic [OUT_W-1:0]        res;

  assign ctrl = '{in_wide: in_wide_i, in_signed: in_signed_i,
                  out_signed: out_signed_i, sat_en: sat_en_i,
                  round_en: round_en_i, out_w16: out_w16_i, shift: shift_i};

  nsu_extend #(.IN_W(IN_W), .EXT_W(EXT_W)) i_extend (
    .data_i(in_data_i), .ctrl_i(ctrl), .ext_o(ext)
  );

  nsu_shift #(.EXT_W(EXT_W)) i_shift (
    .ext_i(ext), .ctrl_i(ctrl), .shifted_o(shifted)
  );

  nsu_clamp #(.EXT_W(EXT_W), .OUT_W(OUT_W)) i_clamp (
    .val_i(shifted), .ctrl_i(ctrl), .res_o(res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) out_data_o <= res;
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R1
  AST_IDLE_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o)); // R2
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !out_w16_i) |=> (out_data_o[OUT_W-1:OUT_W/2] == '0)); // R10
endmodule

// File: tb/test_nsu_top.sv
module test_nsu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_wide = 1'b0, in_signed = 1'b0, out_signed = 1'b0;
  logic        sat_en = 1'b0, round_en = 1'b0, out_w16 = 1'b0;
  logic [4:0]  shift = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nsu_top i_nsu_top (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_wide_i(in_wide), .in_signed_i(in_signed), .out_signed_i(out_signed),
    .sat_en_i(sat_en), .round_en_i(round_en), .shift_i(shift),
    .out_w16_i(out_w16), .out_valid_o(out_valid), .out_data_o(out_data)
  );

  function automatic logic [15:0] model(logic [31:0] d, bit wide, bit sin, bit sout,
                                        bit sat, bit rnd, int sh, bit w16);
    longint v, hi, lo;
    int w;
    if (wide) v = sin ? longint'($signed(d)) : longint'({32'b0, d});
    else      v = sin ? longint'($signed(d[15:0])) : longint'({48'b0, d[15:0]});
    if (rnd && sh != 0) v = v + (longint'(1) << (sh - 1));
    v = v >>> sh;
    w = w16 ? 16 : 8;
    if (sat) begin
      hi = sout ? (longint'(1) << (w - 1)) - 1 : (longint'(1) << w) - 1;
      lo = sout ? -(longint'(1) << (w - 1)) : 0;
      if (v > hi) v = hi;
      if (sin && v < lo) v = lo;
    end
    return w16 ? 16'(v) : {8'h00, 8'(v)};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one element, sample its result one clock later
  task automatic run_one(string req, logic [31:0] d, bit wide, bit sin, bit sout,
                         bit sat, bit rnd, bit [4:0] sh, bit w16, output logic [15:0] got);
    @(negedge clk);
    in_data = d; in_wide = wide; in_signed = sin; out_signed = sout;
    sat_en = sat; round_en = rnd; shift = sh; out_w16 = w16; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got = out_data;
    check(req, out_data, model(d, wide, sin, sout, sat, rnd, int'(sh), w16));
  endtask

  task automatic t_reset();
    check("R1 reset valid", {15'b0, out_valid}, 16'h0);
    check("R1 reset data", out_data, 16'h0);
  endtask

  task automatic t_valid();
    logic [15:0] g;
    run_one("R1 data", 32'h0000_1234, 1, 0, 0, 0, 0, 5'd0, 1, g);
    @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    check("R1 valid after in_valid", {15'b0, out_valid}, 16'h1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R1 valid drops", {15'b0, out_valid}, 16'h0);
  endtask

  task automatic t_hold();
    logic [15:0] g;
    run_one("R2 load", 32'h0000_00AB, 0, 0, 0, 0, 0, 5'd0, 0, g);
    @(negedge clk);
    in_data = 32'hFFFF_FFFF; shift = 5'd3; out_w16 = 1'b1; sat_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 hold while idle", out_data, 16'h00AB);
  endtask

  task automatic t_extend();
    logic [15:0] g;
    run_one("R3 upper bits ignored", 32'hDEAD_8001, 0, 1, 1, 0, 0, 5'd0, 0, g);
    check("R3 literal", g, 16'h0001);
    run_one("R3 sign extend 16", 32'h0000_8000, 0, 1, 1, 1, 0, 5'd0, 0, g);
    check("R3 neg16 sat", g, 16'h0080);
    run_one("R3 zero extend 16", 32'h0000_8000, 0, 0, 1, 1, 0, 5'd0, 0, g);
    check("R3 uns16 sat", g, 16'h007F);
  endtask

  task automatic t_shift();
    logic [15:0] g;
    run_one("R4 neg fill", 32'h8000_0000, 1, 1, 0, 0, 0, 5'd31, 1, g);
    check("R4 literal", g, 16'hFFFF);
    run_one("R4 uns shift 31", 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 5'd31, 1, g);
    check("R4 literal uns", g, 16'h0001);
    run_one("R4 mid shift", 32'h1234_5678, 1, 1, 0, 0, 0, 5'd12, 1, g);
  endtask

  task automatic t_round();
    logic [15:0] g;
    run_one("R5 half up", 32'h0000_0018, 1, 1, 0, 0, 1, 5'd4, 0, g);
    check("R5 literal 0x18>>4 rnd", g, 16'h0002);
    run_one("R5 below half", 32'h0000_0017, 1, 1, 0, 0, 1, 5'd4, 0, g);
    check("R5 literal 0x17>>4 rnd", g, 16'h0001);
    run_one("R5 zero shift no add", 32'h0000_0007, 1, 1, 0, 0, 1, 5'd0, 0, g);
    check("R5 literal", g, 16'h0007);
    run_one("R5 shift31 round max", 32'hFFFF_FFFF, 1, 0, 0, 0, 1, 5'd31, 1, g);
    check("R5 literal carry", g, 16'h0002);
    run_one("R5 negative half", 32'hFFFF_FFF8, 1, 1, 1, 0, 1, 5'd4, 0, g);
    check("R5 literal -8>>4 rnd", g, 16'h0000);
  endtask

  task automatic t_trunc();
    logic [15:0] g;
    run_one("R6 truncate 8", 32'h0001_2345, 1, 1, 1, 0, 0, 5'd0, 0, g);
    check("R6 literal", g, 16'h0045);
    run_one("R6 truncate 16", 32'h0001_2345, 1, 1, 1, 0, 0, 5'd0, 1, g);
    check("R10 literal 16", g, 16'h2345);
  endtask

  task automatic t_sat_ss();
    logic [15:0] g;
    run_one("R7 at hi", 32'h0000_007F, 1, 1, 1, 1, 0, 5'd0, 0, g);
    check("R7 literal hi", g, 16'h007F);
    run_one("R7 past hi", 32'h0000_0080, 1, 1, 1, 1, 0, 5'd0, 0, g);
    check("R7 literal clamp hi", g, 16'h007F);
    run_one("R7 past lo", 32'hFFFF_FF7F, 1, 1, 1, 1, 0, 5'd0, 0, g);
    check("R7 literal clamp lo", g, 16'h0080);
    run_one("R7 16 lo", 32'h8000_0000, 1, 1, 1, 1, 0, 5'd4, 1, g);
    check("R7 literal 16 lo", g, 16'h8000);
  endtask

  task automatic t_sat_su();
    logic [15:0] g;
    run_one("R8 neg to zero", 32'hFFFF_FFFF, 1, 1, 0, 1, 0, 5'd0, 0, g);
    check("R8 literal", g, 16'h0000);
    run_one("R8 past hi", 32'h0000_0100, 1, 1, 0, 1, 0, 5'd0, 0, g);
    check("R8 literal hi", g, 16'h00FF);
    run_one("R8 16 at hi", 32'h0000_FFFF, 1, 1, 0, 1, 0, 5'd0, 1, g);
    check("R8 literal 16", g, 16'hFFFF);
  endtask

  task automatic t_sat_u();
    logic [15:0] g;
    run_one("R9 uns signed-out", 32'hFFFF_FFFF, 1, 0, 1, 1, 0, 5'd0, 1, g);
    check("R9 literal 7FFF", g, 16'h7FFF);
    run_one("R9 uns uns-out", 32'hFFFF_FFFF, 1, 0, 0, 1, 0, 5'd0, 0, g);
    check("R9 literal FF", g, 16'h00FF);
    run_one("R9 uns in range", 32'h0000_0064, 1, 0, 1, 1, 0, 5'd0, 0, g);
    check("R9 literal 64", g, 16'h0064);
  endtask

  task automatic t_sweep();
    logic [31:0] lfsr = 32'hACE1_1234;
    logic [31:0] r;
    logic [15:0] g;
    for (int i = 0; i < 300; i++) begin
      r = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      run_one("R10 sweep", lfsr, r[0] | r[5], r[1], r[2], r[3], r[4], r[10:6], r[5], g);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_valid();
    t_hold();
    t_extend();
    t_shift();
    t_round();
    t_trunc();
    t_sat_ss();
    t_sat_su();
    t_sat_u();
    t_sweep();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule